// File: doc/BRIEF.md
# Channel Security Filter and Bus-Error Router

This block sits between the register bus of a multi-channel DMA controller and the per-channel register files. Every bus access carries a secure/non-secure attribute. Each channel is separately placed in secure or non-secure mode by an input vector. The block decides which channel register writes may proceed. It masks the read data so that non-secure software never sees a secure channel's register contents or its bits in the shared global registers.

The block also owns the interrupt status for channel bus errors. A routing register, writable only by secure software, can redirect bus errors from non-secure channels into a global secure bus-error status. That status cannot be masked and drives the secure interrupt line until secure software reads it. A secure read clears it. Errors that are not redirected set a per-channel interrupt status bit. Under a per-channel mask, that bit drives either the secure or the non-secure interrupt line, depending on the channel's mode.

Word map, with bit n of each global word belonging to channel n: 0 routing, 1 interrupt mask, 2 channel interrupt status, 3 global interrupt status, 4 global bus-error status, and 16+n the register window of channel n.

Top module: `chan_sec_gate`

## Requirements
- R1: A read of word 16+n returns channel n's read data when the access is secure or channel n is non-secure, and returns zero otherwise. A read of an unmapped word returns zero.
- R2: A write to word 16+n raises bit n of the channel write-enable vector in that same cycle only when the access is secure or channel n is non-secure. No write to any other word raises any write-enable bit.
- R3: In the mask (word 1), status (word 2) and global interrupt status (word 3) words, a non-secure access reads zero in the bits of secure channels, and a non-secure write leaves those bits unchanged.
- R4: The routing word (word 0) changes only on a secure write. A non-secure read of it returns zero.
- R5: A bus-error pulse on a non-secure channel whose routing bit is 1 sets that channel's bit in the global bus-error status (word 4) at the next clock edge. The channel's interrupt status bit is left unchanged.
- R6: A bus-error pulse on a channel that is secure, or whose routing bit is 0, sets its channel interrupt status bit (word 2) at the next clock edge. A routing bit has no effect on a secure channel.
- R7: Each global interrupt status bit reads as 1 exactly when the channel's interrupt status bit or its global bus-error status bit is 1.
- R8: The secure interrupt is high whenever any global bus-error status bit is 1, regardless of the mask. A secure read of word 4 returns the status and clears it at the end of that cycle. An error arriving in the same cycle stays set.
- R9: A non-secure read of word 4 returns zero and leaves the status unchanged.
- R10: Writing 1 to a visible bit of word 2 clears it. A bus error in the same cycle keeps the bit set.
- R11: The non-secure interrupt is high exactly when some non-secure channel has both its status bit and its mask bit set. The secure interrupt is also high when a secure channel has both bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register access valid this cycle |
| regWr | input | 1 | 1 = write, 0 = read |
| regSecure | input | 1 | Access attribute, 1 = secure |
| regAddr | input | ADDR_W | Word address |
| regWdata | input | DATA_W | Write data |
| rdData | output | DATA_W | Filtered read data, valid in the access cycle |
| chSecure | input | NUM_CH | Per-channel mode, 1 = secure |
| errIn | input | NUM_CH | Per-channel bus-error pulses |
| chRdData | input | NUM_CH*DATA_W | Read data of each channel's register window |
| chWe | output | NUM_CH | Filtered channel write enables |
| secIrq | output | 1 | Secure interrupt line |
| nsIrq | output | 1 | Non-secure interrupt line |

## Verification
The bench builds the block with four channels, 32-bit data and a 6-bit address. This makes all sixteen secure/non-secure channel combinations reachable in one sweep. Each combination is crossed with both access attributes on every channel window and every global word. It is also crossed with errors on all channels, both with routing on and with routing off. Expected read values, write enables and interrupt levels come from a bit-vector model of the map in the bench. Dedicated cases cover a clear that collides with a new error, both on the global bus-error status and on the channel status.

// File: rtl/chan_sec_pkg.sv
package chan_sec_pkg;

  localparam int unsigned WA_ROUTE  = 0;
  localparam int unsigned WA_MASK   = 1;
  localparam int unsigned WA_STAT   = 2;
  localparam int unsigned WA_GIS    = 3;
  localparam int unsigned WA_GBES   = 4;
  localparam int unsigned WA_CHBASE = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROUTE,
    SEL_MASK,
    SEL_STAT,
    SEL_GIS,
    SEL_GBES,
    SEL_CHAN
  } rdSel_e;

  typedef struct packed {
    logic   wrRoute;
    logic   wrMask;
    logic   clrStat;
    logic   clrGbes;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/chan_sec_ctrl.sv
module chan_sec_ctrl
  import chan_sec_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regSecure,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NUM_CH-1:0] chSecure,
  output strobe_t           str,
  output logic [IDX_W-1:0]  chIdx,
  output logic [NUM_CH-1:0] visMask,
  output logic [NUM_CH-1:0] chWe
);

  logic              isChan;
  logic [ADDR_W-1:0] chOff;
  logic              chVisible;

  assign chOff  = regAddr - ADDR_W'(WA_CHBASE);
  assign isChan = (regAddr >= ADDR_W'(WA_CHBASE)) &&
                  (regAddr < ADDR_W'(WA_CHBASE + NUM_CH));
  assign chIdx  = chOff[IDX_W-1:0];
  assign chVisible = regSecure || !chSecure[chIdx];

  // Secure accesses see every channel; non-secure ones only non-secure channels.
  assign visMask = regSecure ? '1 : ~chSecure;

  always_comb begin
    str       = '0;
    str.rdSel = SEL_NONE;
    chWe      = '0;
    if (regSel) begin
      case (regAddr)
        ADDR_W'(WA_ROUTE): begin
          if (regSecure) begin
            str.rdSel   = SEL_ROUTE;
            str.wrRoute = regWr;
          end
        end
        ADDR_W'(WA_MASK): begin
          str.rdSel  = SEL_MASK;
          str.wrMask = regWr;
        end
        ADDR_W'(WA_STAT): begin
          str.rdSel   = SEL_STAT;
          str.clrStat = regWr;
        end
        ADDR_W'(WA_GIS): begin
          str.rdSel = SEL_GIS;
        end
        ADDR_W'(WA_GBES): begin
          if (regSecure) begin
            str.rdSel   = SEL_GBES;
            str.clrGbes = !regWr;
          end
        end
        default: begin
          if (isChan && chVisible) begin
            str.rdSel = SEL_CHAN;
            if (regWr) chWe[chIdx] = 1'b1;
          end
        end
      endcase
    end
  end

  // R2: a channel write enable only for an allowed write access
  a_r2_chwe_allowed: assert property (@(posedge clk) disable iff (!rstN)
    (|chWe) |-> (regSel && regWr && (regSecure || !(|(chWe & chSecure)))));

  // R2: at most one channel written per access
  a_r2_chwe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chWe));

  // R4: routing updates only from secure accesses
  a_r4_route_wr_secure: assert property (@(posedge clk) disable iff (!rstN)
    str.wrRoute |-> (regSel && regSecure));

endmodule

// File: rtl/chan_sec_dp.sv
module chan_sec_dp
  import chan_sec_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  str,
  input  logic [IDX_W-1:0]         chIdx,
  input  logic [NUM_CH-1:0]        visMask,
  input  logic [DATA_W-1:0]        regWdata,
  input  logic [NUM_CH-1:0]        chSecure,
  input  logic [NUM_CH-1:0]        errIn,
  input  logic [NUM_CH*DATA_W-1:0] chRdData,
  output logic [DATA_W-1:0]        rdData,
  output logic                     secIrq,
  output logic                     nsIrq
);

  logic [NUM_CH-1:0] routeQ, maskQ, statQ, gbesQ;
  logic [NUM_CH-1:0] routeAct, wBits, field;

  assign routeAct = routeQ & ~chSecure;
  assign wBits    = regWdata[NUM_CH-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeQ <= '0;
      maskQ  <= '0;
      statQ  <= '0;
      gbesQ  <= '0;
    end else begin
      if (str.wrRoute) routeQ <= wBits;
      if (str.wrMask)  maskQ  <= (maskQ & ~visMask) | (wBits & visMask);
      statQ <= (str.clrStat ? (statQ & ~(wBits & visMask)) : statQ)
               | (errIn & ~routeAct);
      gbesQ <= (str.clrGbes ? '0 : gbesQ) | (errIn & routeAct);
    end
  end

  always_comb begin
    field  = '0;
    rdData = '0;
    case (str.rdSel)
      SEL_ROUTE: field = routeQ;
      SEL_MASK:  field = maskQ & visMask;
      SEL_STAT:  field = statQ & visMask;
      SEL_GIS:   field = (statQ | gbesQ) & visMask;
      SEL_GBES:  field = gbesQ;
      default:   field = '0;
    endcase
    if (str.rdSel == SEL_CHAN) rdData = chRdData[int'(chIdx)*DATA_W +: DATA_W];
    else rdData[NUM_CH-1:0] = field;
  end

  assign secIrq = (|gbesQ) || (|(statQ & maskQ & chSecure));
  assign nsIrq  = |(statQ & maskQ & ~chSecure);

  // R5: routed error lands in global bus-error status
  a_r5_routed_to_gbes: assert property (@(posedge clk) disable iff (!rstN)
    (|(errIn & routeQ & ~chSecure)) |=>
      ((gbesQ & $past(errIn & routeQ & ~chSecure)) == $past(errIn & routeQ & ~chSecure)));

  // R6: unrouted error lands in channel status
  a_r6_unrouted_to_stat: assert property (@(posedge clk) disable iff (!rstN)
    (|(errIn & ~(routeQ & ~chSecure))) |=>
      ((statQ & $past(errIn & ~(routeQ & ~chSecure))) == $past(errIn & ~(routeQ & ~chSecure))));

  // R8: global bus-error bits only drop after a secure read
  a_r8_gbes_hold: assert property (@(posedge clk) disable iff (!rstN)
    !str.clrGbes |=> (($past(gbesQ) & ~gbesQ) == '0));

  // R8: pending global bus error keeps the secure line up
  a_r8_secirq_pending: assert property (@(posedge clk) disable iff (!rstN)
    (|gbesQ) |-> secIrq);

endmodule

// File: rtl/chan_sec_gate.sv
module chan_sec_gate
  import chan_sec_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regSel,
  input  logic                     regWr,
  input  logic                     regSecure,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWdata,
  output logic [DATA_W-1:0]        rdData,
  input  logic [NUM_CH-1:0]        chSecure,
  input  logic [NUM_CH-1:0]        errIn,
  input  logic [NUM_CH*DATA_W-1:0] chRdData,
  output logic [NUM_CH-1:0]        chWe,
  output logic                     secIrq,
  output logic                     nsIrq
);

  strobe_t           str;
  logic [IDX_W-1:0]  chIdx;
  logic [NUM_CH-1:0] visMask;

  chan_sec_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regSecure(regSecure), .regAddr(regAddr), .chSecure(chSecure),
    .str(str), .chIdx(chIdx), .visMask(visMask), .chWe(chWe)
  );

  chan_sec_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .str(str), .chIdx(chIdx), .visMask(visMask),
    .regWdata(regWdata), .chSecure(chSecure), .errIn(errIn),
    .chRdData(chRdData), .rdData(rdData), .secIrq(secIrq), .nsIrq(nsIrq)
  );

  // R9: non-secure read of the global bus-error word returns zero
  a_r9_ns_gbes_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWr && !regSecure && regAddr == ADDR_W'(WA_GBES)) |-> (rdData == '0));

  // R4: non-secure read of the routing word returns zero
  a_r4_ns_route_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWr && !regSecure && regAddr == ADDR_W'(WA_ROUTE)) |-> (rdData == '0));

endmodule

// File: tb/chan_sec_gate_tb_top.sv
`timescale 1ns/1ps
module chan_sec_gate_tb_top;

  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int AW  = 6;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           regSel = 1'b0, regWr = 1'b0, regSecure = 1'b0;
  logic [AW-1:0]  regAddr = '0;
  logic [DW-1:0]  regWdata = '0;
  logic [DW-1:0]  rdData;
  logic [NCH-1:0] chSecure = '0, errIn = '0, chWe;
  logic [NCH*DW-1:0] chRdData;
  logic           secIrq, nsIrq;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  logic [3:0] mRoute, mMask, mStat, mGbes, sc;

  always #2.5 clk = ~clk;

  chan_sec_gate #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regSecure(regSecure), .regAddr(regAddr), .regWdata(regWdata),
    .rdData(rdData), .chSecure(chSecure), .errIn(errIn),
    .chRdData(chRdData), .chWe(chWe), .secIrq(secIrq), .nsIrq(nsIrq)
  );

  function automatic logic [31:0] pat(input int ch);
    return 32'h5A5A_0000 + 32'(ch * 17);
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) chRdData[c*DW +: DW] = pat(c);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input int addr, input logic [31:0] wd,
                        input logic sec, output logic [31:0] rd, output logic [3:0] we);
    @(negedge clk);
    regSel = 1'b1; regWr = wr; regAddr = AW'(addr); regWdata = wd; regSecure = sec;
    #1;
    rd = rdData;
    we = chWe;
    @(posedge clk);
    #1;
    regSel = 1'b0; regWr = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [31:0] wd, input logic sec);
    logic [31:0] rd; logic [3:0] we;
    access(1'b1, addr, wd, sec, rd, we);
  endtask

  task automatic rd(input int addr, input logic sec, output logic [31:0] val);
    logic [3:0] we;
    access(1'b0, addr, '0, sec, val, we);
  endtask

  task automatic pulseErr(input logic [3:0] v);
    @(negedge clk); errIn = v;
    @(negedge clk); errIn = '0;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] v;
    rd(0, 1'b1, v); chk({req, " R4 route sec"}, v, {28'h0, mRoute});
    rd(0, 1'b0, v); chk({req, " R4 route ns"}, v, 32'h0);
    rd(1, 1'b1, v); chk({req, " R3 mask sec"}, v, {28'h0, mMask});
    rd(1, 1'b0, v); chk({req, " R3 mask ns"}, v, {28'h0, mMask & ~sc});
    rd(2, 1'b1, v); chk({req, " R3 stat sec"}, v, {28'h0, mStat});
    rd(2, 1'b0, v); chk({req, " R3 stat ns"}, v, {28'h0, mStat & ~sc});
    rd(3, 1'b1, v); chk({req, " R7 gis sec"}, v, {28'h0, mStat | mGbes});
    rd(3, 1'b0, v); chk({req, " R7 gis ns"}, v, {28'h0, (mStat | mGbes) & ~sc});
    @(negedge clk); #1;
    chk({req, " R11 secIrq"}, {31'h0, secIrq},
        {31'h0, (|mGbes) || (|(mStat & mMask & sc))});
    chk({req, " R11 nsIrq"}, {31'h0, nsIrq}, {31'h0, |(mStat & mMask & ~sc)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [3:0] we;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset secIrq", {31'h0, secIrq}, 32'h0);
    chk("R11 reset nsIrq", {31'h0, nsIrq}, 32'h0);
    rstN = 1'b1;
    sc = '0; mRoute = '0; mMask = '0; mStat = '0; mGbes = '0;
    checkAll("reset");

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sc = 4'(i);
      chSecure = sc;
      wr(0, 0, 1'b1); wr(1, 0, 1'b1); wr(2, 32'hF, 1'b1); rd(4, 1'b1, v);
      mRoute = '0; mMask = '0; mStat = '0; mGbes = '0;
      checkAll("init");

      // R1 / R2: channel windows
      for (int c = 0; c < NCH; c++) begin
        for (int s = 0; s < 2; s++) begin
          logic ok;
          ok = (s == 1) || !sc[c];
          access(1'b0, 16 + c, '0, 1'(s), v, we);
          chk("R1 chan read", v, ok ? pat(c) : 32'h0);
          chk("R2 chan read no we", {28'h0, we}, 32'h0);
          access(1'b1, 16 + c, 32'h1234, 1'(s), v, we);
          chk("R2 chan write we", {28'h0, we}, ok ? 32'(1 << c) : 32'h0);
        end
      end
      access(1'b0, 8, '0, 1'b1, v, we);
      chk("R1 unmapped read", v, 32'h0);
      access(1'b1, 0, 32'h0, 1'b1, v, we);
      chk("R2 global write no we", {28'h0, we}, 32'h0);

      // R4: routing word
      wr(0, 32'hF, 1'b0);
      checkAll("R4 ns write");
      wr(0, 32'hF, 1'b1); mRoute = 4'hF;
      checkAll("R4 sec write");

      // R3: mask bits of secure channels protected
      wr(1, 32'hF, 1'b0); mMask = ~sc;
      checkAll("R3 ns mask write");

      // R5 / R6: routed errors
      pulseErr(4'hF); mGbes = ~sc; mStat = sc;
      checkAll("R5 R6 routed");

      // R9 / R8
      rd(4, 1'b0, v); chk("R9 ns gbes read", v, 32'h0);
      rd(4, 1'b1, v); chk("R9 gbes kept", v, {28'h0, mGbes});
      mGbes = '0;
      rd(4, 1'b1, v); chk("R8 gbes cleared", v, 32'h0);
      checkAll("R8 after clear");

      // R10 / R6 / R11
      wr(2, 32'hF, 1'b0); mStat = mStat & sc;
      checkAll("R10 ns w1c");
      wr(0, 32'h0, 1'b1); mRoute = '0;
      pulseErr(4'hF); mStat = 4'hF;
      checkAll("R6 unrouted");
      wr(2, 32'hF, 1'b0); mStat = sc;
      checkAll("R10 ns w1c secure kept");
      wr(1, 32'hF, 1'b1); mMask = 4'hF;
      checkAll("R11 secure mask");
      wr(2, 32'hF, 1'b1); mStat = '0;
      checkAll("R10 sec w1c");
    end

    // R8: error colliding with a secure clear of the global status
    @(negedge clk); sc = '0; chSecure = '0;
    wr(0, 32'hF, 1'b1); wr(1, 32'h0, 1'b1);
    pulseErr(4'h1);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b0; regAddr = AW'(4); regSecure = 1'b1; errIn = 4'h2;
    #1; v = rdData;
    chk("R8 collide read", v, 32'h1);
    @(negedge clk); regSel = 1'b0; errIn = '0;
    rd(4, 1'b1, v); chk("R8 collide set wins", v, 32'h2);

    // R10: error colliding with a status clear
    wr(0, 32'h0, 1'b1);
    pulseErr(4'h1);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; regAddr = AW'(2); regWdata = 32'h1; regSecure = 1'b1;
    errIn = 4'h1;
    @(negedge clk); regSel = 1'b0; regWr = 1'b0; errIn = '0;
    rd(2, 1'b1, v); chk("R10 collide set wins", v, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule